// File: doc/BRIEF.md
# Receive Character Buffer with Per-Character Error Status

This block sits between a serial receiver's shift register and a processor-facing register file. Each character that the receiver finishes is written into a first-in first-out store along with its break, parity-error and framing-error flags, so that the flags stay with their own character until it reaches the head. Software reads characters through a data word that shows the head character's data and flags, plus a flag for a pending overrun.

A second, sticky status word collects the error flags of characters as they are read. It also records an overrun as soon as one happens. Any write strobe to the error-clear location wipes it. When the buffered mode is switched off, the store acts as a single holding register. A character that arrives while no space is left is dropped. The characters already stored are kept.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset, `rdWord` and `stsWord` read 0, `rxEmpty` is 1 and `rxFull` is 0.
- R2: Characters are read back in arrival order. `rdWord` bits 7:0 hold the head character, bits 15:12 read 0, and one pulse of `rdStrobe` moves to the next character.
- R3: `rdWord` bit 10 (break), bit 9 (parity error) and bit 8 (framing error) show the flags that arrived with the character now at the head.
- R4: A character offered while the store is full and no read happens in the same cycle is not stored, and every stored character is still read back unchanged.
- R5: `rdWord` bit 11 is 1 from the cycle after an overrun. It returns to 0 after the next read frees a slot.
- R6: `stsWord` bit 3 is 1 from the cycle after an overrun and stays 1 until the next clear.
- R7: `stsWord` bit 2 (break), bit 1 (parity) and bit 0 (framing) accumulate the flags of characters already read. A flag of a character that is still unread does not appear there.
- R8: A `clrStrobe` pulse clears `stsWord` bits 3:0 in the next cycle.
- R9: With `fifoEn` at 0 the store holds one character. A second arrival before a read is an overrun.
- R10: A read while empty leaves `rdWord` at the last character read and moves no pointer, so the next character is stored and read correctly.
- R11: A read and an arrival in the same cycle while full both take effect, with no overrun.
- R12: `rxFull` is 1 exactly when 16 characters (1 when `fifoEn` is 0) are stored, and `rxEmpty` is 1 exactly when none are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | 1: 16-entry buffer, 0: one-entry holding register (change only while empty) |
| wrValid | input | 1 | Receiver offers a character this cycle |
| wrData | input | 8 | Received character |
| wrBrk | input | 1 | Break flag for the offered character |
| wrPar | input | 1 | Parity-error flag for the offered character |
| wrFrm | input | 1 | Framing-error flag for the offered character |
| rdStrobe | input | 1 | Data word read, pops the head |
| clrStrobe | input | 1 | Write to the error-clear location |
| rdWord | output | 16 | {0000, overrun, break, parity, framing, data} |
| stsWord | output | 8 | {0000, overrun, break, parity, framing}, sticky |
| rxEmpty | output | 1 | No character stored |
| rxFull | output | 1 | No space left |

## Verification
A read pointer that is off by one shows in `rdWord` on the very next sample. It shows either as data out of order or as flags attached to the wrong neighbour, which the flagged characters placed between clean ones reveal. An occupancy count that is wrong shows at the full boundary. A stored character is lost, or an accepted one is wrongly reported as an overrun through bit 3 of `stsWord` one cycle later. Status that follows the head rather than the last read character shows before the flagged character is ever read.

// File: rtl/rx_status_fifo_pkg.sv
package rx_status_fifo_pkg;
  localparam int CHAR_W = 8;
  localparam int RD_W   = 16;
  localparam int STS_W  = 8;

  typedef struct packed {
    logic              brk;
    logic              par;
    logic              frm;
    logic [CHAR_W-1:0] data;
  } rxEntry_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic ovr;
    logic clr;
  } fifoCtl_t;
endpackage

// File: rtl/rx_status_fifo_ctrl.sv
module rx_status_fifo_ctrl
  import rx_status_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             wrValid,
  input  logic             rdStrobe,
  input  logic             clrStrobe,
  output fifoCtl_t         ctl,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             isEmpty,
  output logic             isFull
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] capacity;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    capacity = fifoEn ? CNT_W'(DEPTH) : CNT_W'(1);
    isEmpty  = (count == '0);
    isFull   = (count >= capacity);
    ctl.pop  = rdStrobe & ~isEmpty;
    ctl.push = wrValid & (~isFull | ctl.pop);
    ctl.ovr  = wrValid & ~ctl.push;
    ctl.clr  = clrStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctl.push) wrPtr <= advance(wrPtr);
      if (ctl.pop)  rdPtr <= advance(rdPtr);
      case ({ctl.push, ctl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rx_status_fifo_dp.sv
module rx_status_fifo_dp
  import rx_status_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoCtl_t         ctl,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic             isEmpty,
  input  rxEntry_t         wrEntry,
  output logic [RD_W-1:0]  rdWord,
  output logic [STS_W-1:0] stsWord
);
  rxEntry_t   store [DEPTH];
  rxEntry_t   lastRead;
  rxEntry_t   head;
  logic       ovrFlag;
  logic [3:0] stsBits;
  logic [3:0] stsNext;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (ctl.push && wrPtr == PTR_W'(i)) store[i] <= wrEntry;
    end
  end

  always_comb begin
    head    = isEmpty ? lastRead : store[rdPtr];
    rdWord  = RD_W'({ovrFlag, head});
    stsWord = STS_W'(stsBits);
    stsNext = ctl.clr ? 4'b0 : stsBits;
    if (ctl.ovr) stsNext[3] = 1'b1;
    if (ctl.pop) stsNext[2:0] = stsNext[2:0] | {head.brk, head.par, head.frm};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastRead <= '0;
      ovrFlag  <= 1'b0;
      stsBits  <= '0;
    end else begin
      stsBits <= stsNext;
      if (ctl.pop) lastRead <= head;
      if (ctl.ovr)      ovrFlag <= 1'b1;
      else if (ctl.pop) ovrFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
  import rx_status_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEn,
  input  logic              wrValid,
  input  logic [CHAR_W-1:0] wrData,
  input  logic              wrBrk,
  input  logic              wrPar,
  input  logic              wrFrm,
  input  logic              rdStrobe,
  input  logic              clrStrobe,
  output logic [RD_W-1:0]   rdWord,
  output logic [STS_W-1:0]  stsWord,
  output logic              rxEmpty,
  output logic              rxFull
);
  fifoCtl_t         ctl;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  rxEntry_t         wrEntry;

  assign wrEntry = '{brk: wrBrk, par: wrPar, frm: wrFrm, data: wrData};

  rx_status_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .wrValid(wrValid),
    .rdStrobe(rdStrobe), .clrStrobe(clrStrobe), .ctl(ctl),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .isEmpty(rxEmpty), .isFull(rxFull)
  );

  rx_status_fifo_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .isEmpty(rxEmpty), .wrEntry(wrEntry), .rdWord(rdWord), .stsWord(stsWord)
  );
endmodule

// File: rtl/rx_status_fifo_chk.sv
module rx_status_fifo_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrValid,
  input logic        rdStrobe,
  input logic        clrStrobe,
  input logic [11:0] rdWord,
  input logic [3:0]  stsWord,
  input logic        rxEmpty,
  input logic        rxFull
);
  // R4 / R6: an arrival that finds no room must register as an overrun
  a_r4_drop_when_full: assert property (@(posedge clk) disable iff (!rstN)
    rxFull && wrValid && !rdStrobe |=> stsWord[3]);

  // R6: overrun status is sticky until a clear
  a_r6_sticky_ovr: assert property (@(posedge clk) disable iff (!rstN)
    stsWord[3] && !clrStrobe |=> stsWord[3]);

  // R5: the data word carries the overrun mark when status records it
  a_r5_ovr_in_word: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsWord[3]) |-> rdWord[11]);

  // R8: a clear with no other activity empties the status word
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrStrobe && !wrValid && !rdStrobe |=> stsWord == 4'b0);

  // R10: reading while empty leaves the shown character untouched
  a_r10_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    rxEmpty && rdStrobe && !wrValid |=> $stable(rdWord[10:0]) && rxEmpty);

  // R12: full cannot drop without a read, and never coexists with empty
  a_r12_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    rxFull && !rdStrobe |=> rxFull);
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rxFull && rxEmpty));
endmodule

bind rx_status_fifo rx_status_fifo_chk u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdStrobe(rdStrobe),
  .clrStrobe(clrStrobe), .rdWord(rdWord[11:0]), .stsWord(stsWord[3:0]),
  .rxEmpty(rxEmpty), .rxFull(rxFull)
);

// File: tb/tb_rx_status_fifo.sv
module tb_rx_status_fifo;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fifoEn = 1'b1;
  logic        wrValid = 1'b0;
  logic [7:0]  wrData = '0;
  logic        wrBrk = 1'b0, wrPar = 1'b0, wrFrm = 1'b0;
  logic        rdStrobe = 1'b0, clrStrobe = 1'b0;
  logic [15:0] rdWord;
  logic [7:0]  stsWord;
  logic        rxEmpty, rxFull;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rx_status_fifo dut (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .wrValid(wrValid), .wrData(wrData),
    .wrBrk(wrBrk), .wrPar(wrPar), .wrFrm(wrFrm), .rdStrobe(rdStrobe),
    .clrStrobe(clrStrobe), .rdWord(rdWord), .stsWord(stsWord),
    .rxEmpty(rxEmpty), .rxFull(rxFull)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one clock: drive at falling edge, release just after the rising edge
  task automatic cyc(input logic wv, input logic [7:0] d, input logic [2:0] bpf,
                     input logic rd, input logic clr);
    @(negedge clk);
    wrValid = wv; wrData = d; {wrBrk, wrPar, wrFrm} = bpf;
    rdStrobe = rd; clrStrobe = clr;
    @(posedge clk); #1;
    wrValid = 0; rdStrobe = 0; clrStrobe = 0; {wrBrk, wrPar, wrFrm} = 3'b0;
  endtask

  task automatic put(input logic [7:0] d, input logic [2:0] bpf);
    cyc(1'b1, d, bpf, 1'b0, 1'b0);
  endtask
  task automatic take();
    cyc(1'b0, 8'h0, 3'b0, 1'b1, 1'b0);
  endtask
  task automatic clearSts();
    cyc(1'b0, 8'h0, 3'b0, 1'b0, 1'b1);
  endtask

  task automatic testReset();
    check("R1 rdWord", rdWord, 16'h0);
    check("R1 stsWord", 16'(stsWord), 16'h0);
    check("R1 empty", 16'(rxEmpty), 16'h1);
    check("R1 full", 16'(rxFull), 16'h0);
  endtask

  task automatic testOrderAndFlags();
    put(8'hA5, 3'b000);
    put(8'h3C, 3'b010);
    put(8'h0F, 3'b001);
    check("R2 head first", rdWord, 16'h00A5);
    take();
    check("R3 parity with head", rdWord, 16'h023C);
    check("R7 unread parity not in status", 16'(stsWord), 16'h0);
    take();
    check("R3 framing with head", rdWord, 16'h010F);
    check("R7 parity after read", 16'(stsWord), 16'h2);
    take();
    check("R7 accumulated", 16'(stsWord), 16'h3);
    check("R12 empty after drain", 16'(rxEmpty), 16'h1);
    clearSts();
    check("R8 clear", 16'(stsWord), 16'h0);
    put(8'h00, 3'b100);
    check("R3 break with head", rdWord, 16'h0400);
    take();
    check("R7 break after read", 16'(stsWord), 16'h4);
    clearSts();
    check("R8 clear break", 16'(stsWord), 16'h0);
  endtask

  task automatic testOverrun();
    for (int i = 0; i < 16; i++) put(8'(i), 3'b000);
    check("R12 full at 16", 16'(rxFull), 16'h1);
    put(8'hEE, 3'b111);
    check("R6 overrun status", 16'(stsWord), 16'h8);
    check("R5 overrun in word", rdWord, 16'h0800);
    take();
    check("R5 overrun mark cleared", rdWord, 16'h0001);
    check("R6 overrun sticky", 16'(stsWord), 16'h8);
    for (int i = 1; i < 16; i++) begin
      check("R4 stored data intact", rdWord[7:0], 16'(i));
      take();
    end
    check("R4 dropped char absent", 16'(rxEmpty), 16'h1);
    check("R10 last read shown", rdWord, 16'h000F);
    take();
    check("R10 empty read no change", rdWord, 16'h000F);
    check("R10 still empty", 16'(rxEmpty), 16'h1);
    put(8'h5A, 3'b000);
    check("R10 pointers intact", rdWord, 16'h005A);
    take();
    clearSts();
    check("R8 clear overrun", 16'(stsWord), 16'h0);
  endtask

  task automatic testReadWriteFull();
    for (int i = 0; i < 16; i++) put(8'(8'h10 + i), 3'b000);
    cyc(1'b1, 8'h77, 3'b000, 1'b1, 1'b0);
    check("R11 no overrun", 16'(stsWord), 16'h0);
    check("R11 still full", 16'(rxFull), 16'h1);
    check("R11 head advanced", rdWord, 16'h0011);
    for (int i = 0; i < 15; i++) take();
    check("R11 new char stored", rdWord, 16'h0077);
    take();
    check("R12 empty", 16'(rxEmpty), 16'h1);
  endtask

  task automatic testHolding();
    fifoEn = 1'b0;
    put(8'h11, 3'b000);
    check("R9 full at one", 16'(rxFull), 16'h1);
    put(8'h22, 3'b000);
    check("R9 overrun status", 16'(stsWord), 16'h8);
    check("R9 held char kept", rdWord, 16'h0811);
    take();
    check("R9 read held char", rdWord, 16'h0011);
    check("R9 empty", 16'(rxEmpty), 16'h1);
    clearSts();
    fifoEn = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testOrderAndFlags();
    testOverrun();
    testReadWriteFull();
    testHolding();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule